// File: doc/BRIEF.md
# Debug memory access sequencer

This block sits behind a debug host link and gives the host reach into the processor's storage. The host sees three 16-bit registers: an address, a data value and a command word. To read or write memory, program space, peripheral registers or a CPU register, the host loads the address, loads the data if it is writing, and then writes the command word with its launch bit set. The block then runs a single access on a single-master memory bus or on the register-file port. For a read, it places the result in the data register.

A command can target the register file or memory, can read or write, and for memory can move a whole 16-bit word or a single byte. For a byte access, the low address bit picks the byte lane. A byte read comes back zero-extended. A byte write takes the low byte of the data register, and the other lane of the target word keeps its value. No address range is protected, so the vector area at the top of the space can be written like any other location. While an access runs, the command word reports busy and the block ignores every host write.

Top module: `dbg_mem_access`

## Requirements
- R1: After reset the address, data and command registers all read zero, `mem_en` and `rf_we` are low, and `host_rdata` reads zero on every select.
- R2: `host_sel` selects 0 = address, 1 = data, 2 = command and 3 = unused. A host write to selects 0 to 2 while idle is stored and reads back on `host_rdata`. Select 3 always reads zero.
- R3: The command word uses bit 0 = launch, bit 1 = write, bit 2 = register file and bit 3 = byte. A command written with bit 0 clear is stored as written and starts no bus activity.
- R4: Command 0x0001 drives one cycle of `mem_en`, with `mem_we` = 0 and `mem_addr` = address bits [15:1]. The returned word is in the data register two cycles after the clock edge that took the command.
- R5: Command 0x0003 drives one cycle of `mem_en` with `mem_we` = 2'b11 and `mem_wdata` = data register, in the cycle right after the command edge.
- R6: Command 0x0009 returns, zero-extended in the data register, the low byte of the word for an even address and the high byte for an odd address.
- R7: Command 0x000B drives the data register's low byte on both lanes of `mem_wdata`, with `mem_we` = 2'b01 for an even address and 2'b10 for an odd address. The other byte of the stored word is unchanged.
- R8: Command 0x0005 copies `rf_rdata` for index address[3:0] into the data register one cycle after the command edge and never raises `mem_en`.
- R9: Command 0x0007 raises `rf_we` for exactly one cycle with `rf_idx` = address[3:0] and `rf_wdata` = data register.
- R10: While an access is in progress, the command word reads back with bit 0 and bit 4 (busy) set. When the access finishes, both clear and the other command bits keep their value.
- R11: A host write to any register while busy is ignored, and this includes a new launch.
- R12: Every 16-bit address reaches the bus unfiltered, including the vector area at 0xFFE0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 2 | Host register select |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 16 | Host write data |
| host_rdata | output | 16 | Selected register contents |
| mem_addr | output | 15 | Memory word address |
| mem_en | output | 1 | Memory access enable |
| mem_we | output | 2 | Per-byte write enables |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid one cycle after enable |
| rf_idx | output | 4 | Register-file index |
| rf_we | output | 1 | Register-file write enable |
| rf_wdata | output | 16 | Register-file write data |
| rf_rdata | input | 16 | Register-file read data (combinational) |

## Verification
The access path is exercised with word reads and writes, with byte reads and writes at both an even and an odd address, and with register-file reads and writes. Comparing even and odd byte cases separates a wrong lane choice from a wrong zero-extension. Comparing register-file commands with memory commands shows whether the target-select bit keeps the memory bus quiet. A write to the vector area at the top of the map checks that no address filtering exists. A host write issued in the cycle after a launch checks that the busy lock protects the data register, and a command written without the launch bit checks that storing a command does not by itself start an access.

// File: rtl/dbgmem_pkg.sv
package dbgmem_pkg;
  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_DATA = 2'd1;
  localparam logic [1:0] SEL_CMD  = 2'd2;
  localparam int         BUSY_BIT = 4;

  // command word, bit 0 launch .. bit 3 byte width
  typedef struct packed {
    logic byte_w;
    logic regf;
    logic write;
    logic launch;
  } cmd_t;

  typedef enum logic [1:0] {
    ACC_IDLE    = 2'd0,
    ACC_ISSUE   = 2'd1,
    ACC_CAPTURE = 2'd2
  } acc_state_e;
endpackage

// File: rtl/dbgmem_rst_sync.sv
module dbgmem_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/dbgmem_seq.sv
module dbgmem_seq
  import dbgmem_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic launch,
  input  cmd_t cmd,
  output logic busy,
  output logic mem_go,
  output logic rf_wr,
  output logic rf_cap,
  output logic mem_cap,
  output logic done
);
  acc_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    case (state_q)
      ACC_IDLE:    if (launch) state_d = ACC_ISSUE;
      ACC_ISSUE:   state_d = (cmd.regf || cmd.write) ? ACC_IDLE : ACC_CAPTURE;
      ACC_CAPTURE: state_d = ACC_IDLE;
      default:     state_d = ACC_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ACC_IDLE;
    else        state_q <= state_d;
  end

  assign busy    = (state_q != ACC_IDLE);
  assign mem_go  = (state_q == ACC_ISSUE) && !cmd.regf;
  assign rf_wr   = (state_q == ACC_ISSUE) && cmd.regf && cmd.write;
  assign rf_cap  = (state_q == ACC_ISSUE) && cmd.regf && !cmd.write;
  assign mem_cap = (state_q == ACC_CAPTURE);
  assign done    = busy && (state_d == ACC_IDLE);
endmodule

// File: rtl/dbgmem_lanes.sv
module dbgmem_lanes #(
  parameter int DATA_W = 16,
  localparam int LANES  = DATA_W / 8,
  localparam int LSEL_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              byte_mode,
  input  logic [LSEL_W-1:0] lane_sel,
  input  logic [DATA_W-1:0] wr_src,
  input  logic [DATA_W-1:0] rd_word,
  output logic [LANES-1:0]  lane_we,
  output logic [DATA_W-1:0] wr_word,
  output logic [DATA_W-1:0] rd_value
);
  logic [7:0] picked;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_we[i]       = !byte_mode || (lane_sel == LSEL_W'(i));
    assign wr_word[i*8 +: 8] = byte_mode ? wr_src[7:0] : wr_src[i*8 +: 8];
  end

  always_comb begin
    picked = 8'h00;
    for (int i = 0; i < LANES; i++)
      if (lane_sel == LSEL_W'(i)) picked = rd_word[i*8 +: 8];
  end

  assign rd_value = byte_mode ? {{(DATA_W-8){1'b0}}, picked} : rd_word;
endmodule

// File: rtl/dbg_mem_access.sv
module dbg_mem_access
  import dbgmem_pkg::*;
#(
  parameter int ADDR_W   = 16,
  parameter int DATA_W   = 16,
  parameter int RF_IDX_W = 4,
  localparam int LANES   = DATA_W / 8,
  localparam int LSEL_W  = (LANES > 1) ? $clog2(LANES) : 1,
  localparam int WADDR_W = ADDR_W - LSEL_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [1:0]         host_sel,
  input  logic               host_wr,
  input  logic [DATA_W-1:0]  host_wdata,
  output logic [DATA_W-1:0]  host_rdata,
  output logic [WADDR_W-1:0] mem_addr,
  output logic               mem_en,
  output logic [LANES-1:0]   mem_we,
  output logic [DATA_W-1:0]  mem_wdata,
  input  logic [DATA_W-1:0]  mem_rdata,
  output logic [RF_IDX_W-1:0] rf_idx,
  output logic               rf_we,
  output logic [DATA_W-1:0]  rf_wdata,
  input  logic [DATA_W-1:0]  rf_rdata
);
  logic              rst_ns;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;
  cmd_t              cmd_q, cmd_d;
  logic              busy, mem_go, rf_wr, rf_cap, mem_cap, done;
  logic              host_en, launch;
  logic [LANES-1:0]  lane_we;
  logic [DATA_W-1:0] wr_word, rd_value;

  dbgmem_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_n_sync(rst_ns));

  assign host_en = host_wr && !busy;
  assign launch  = host_en && (host_sel == SEL_CMD) && host_wdata[0];

  dbgmem_seq u_seq (
    .clk(clk), .rst_n(rst_ns), .launch(launch), .cmd(cmd_q),
    .busy(busy), .mem_go(mem_go), .rf_wr(rf_wr), .rf_cap(rf_cap),
    .mem_cap(mem_cap), .done(done)
  );

  dbgmem_lanes #(.DATA_W(DATA_W)) u_lanes (
    .byte_mode(cmd_q.byte_w), .lane_sel(addr_q[LSEL_W-1:0]),
    .wr_src(data_q), .rd_word(mem_rdata),
    .lane_we(lane_we), .wr_word(wr_word), .rd_value(rd_value)
  );

  // next-state for host-visible registers
  always_comb begin
    addr_d = addr_q;
    data_d = data_q;
    cmd_d  = cmd_q;
    if (host_en && host_sel == SEL_ADDR) addr_d = host_wdata[ADDR_W-1:0];
    if (host_en && host_sel == SEL_DATA) data_d = host_wdata;
    if (host_en && host_sel == SEL_CMD)  cmd_d  = cmd_t'(host_wdata[3:0]);
    if (rf_cap)  data_d = rf_rdata;
    if (mem_cap) data_d = rd_value;
    if (done)    cmd_d.launch = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      addr_q <= '0;
      data_q <= '0;
      cmd_q  <= '0;
    end else begin
      addr_q <= addr_d;
      data_q <= data_d;
      cmd_q  <= cmd_d;
    end
  end

  always_comb begin
    case (host_sel)
      SEL_ADDR: host_rdata = DATA_W'(addr_q);
      SEL_DATA: host_rdata = data_q;
      SEL_CMD:  host_rdata = {{(DATA_W-BUSY_BIT-1){1'b0}}, busy, cmd_q};
      default:  host_rdata = '0;
    endcase
  end

  assign mem_en    = mem_go;
  assign mem_addr  = addr_q[ADDR_W-1:LSEL_W];
  assign mem_we    = (mem_go && cmd_q.write) ? lane_we : '0;
  assign mem_wdata = wr_word;
  assign rf_idx    = addr_q[RF_IDX_W-1:0];
  assign rf_we     = rf_wr;
  assign rf_wdata  = data_q;
endmodule

// File: rtl/dbgmem_chk.sv
module dbgmem_chk #(
  parameter int ADDR_W = 16,
  parameter int LANES  = 2
) (
  input logic              clk,
  input logic              rst_ns,
  input logic              host_wr,
  input logic [1:0]        host_sel,
  input logic              host_bit0,
  input logic              busy,
  input logic              mem_en,
  input logic [LANES-1:0]  mem_we,
  input logic              rf_we,
  input logic              cmd_byte,
  input logic              cmd_write,
  input logic              cmd_launch,
  input logic [ADDR_W-1:0] addr_q
);
  p_bus_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    !(mem_en && rf_we));
  p_we_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_we != '0) |-> mem_en);
  p_byte_one_lane_r7: assert property (@(posedge clk) disable iff (!rst_ns)
    (mem_en && cmd_byte && cmd_write) |-> $onehot(mem_we));
  p_single_beat_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    mem_en |=> !mem_en);
  p_rf_single_r9: assert property (@(posedge clk) disable iff (!rst_ns)
    rf_we |=> !rf_we);
  p_launch_busy_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    (host_wr && host_sel == 2'd2 && host_bit0 && !busy) |=> busy);
  p_launch_tracks_busy_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |-> cmd_launch);
  p_addr_locked_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    busy |=> $stable(addr_q));
endmodule

bind dbg_mem_access dbgmem_chk #(.ADDR_W(ADDR_W), .LANES(LANES)) u_chk (
  .clk(clk), .rst_ns(rst_ns), .host_wr(host_wr), .host_sel(host_sel),
  .host_bit0(host_wdata[0]), .busy(busy), .mem_en(mem_en), .mem_we(mem_we),
  .rf_we(rf_we), .cmd_byte(cmd_q.byte_w), .cmd_write(cmd_q.write),
  .cmd_launch(cmd_q.launch), .addr_q(addr_q)
);

// File: tb/sim_dbg_mem_access.sv
`timescale 1ns/1ps
module sim_dbg_mem_access;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [1:0]  host_sel;
  logic        host_wr;
  logic [15:0] host_wdata, host_rdata;
  logic [14:0] mem_addr;
  logic        mem_en;
  logic [1:0]  mem_we;
  logic [15:0] mem_wdata, mem_rdata;
  logic [3:0]  rf_idx;
  logic        rf_we;
  logic [15:0] rf_wdata, rf_rdata;

  int checks = 0;
  int errors = 0;

  logic [15:0] mem [256];
  logic [15:0] rf  [16];

  always #10 clk = ~clk;

  dbg_mem_access u0 (
    .clk(clk), .rst_n(rst_n), .host_sel(host_sel), .host_wr(host_wr),
    .host_wdata(host_wdata), .host_rdata(host_rdata), .mem_addr(mem_addr),
    .mem_en(mem_en), .mem_we(mem_we), .mem_wdata(mem_wdata),
    .mem_rdata(mem_rdata), .rf_idx(rf_idx), .rf_we(rf_we),
    .rf_wdata(rf_wdata), .rf_rdata(rf_rdata)
  );

  // bench memory: registered read, per-byte write
  always @(posedge clk) begin
    if (mem_en) begin
      mem_rdata <= mem[mem_addr[7:0]];
      if (mem_we[0]) mem[mem_addr[7:0]][7:0]  <= mem_wdata[7:0];
      if (mem_we[1]) mem[mem_addr[7:0]][15:8] <= mem_wdata[15:8];
    end
    if (rf_we) rf[rf_idx] <= rf_wdata;
  end
  assign rf_rdata = rf[rf_idx];

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic host_write(input logic [1:0] sel, input logic [15:0] d);
    @(negedge clk);
    host_sel = sel; host_wdata = d; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic host_read(input logic [1:0] sel, output logic [15:0] d);
    host_sel = sel;
    #1 d = host_rdata;
  endtask

  task automatic settle();
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    for (int s = 0; s < 4; s++) begin
      host_read(s[1:0], v);
      chk("R1 reset readback", v, 16'h0000);
    end
    chk("R1 bus idle", {14'b0, mem_en, rf_we}, 16'h0000);
  endtask

  task automatic t_regs();
    logic [15:0] v;
    host_write(2'd0, 16'h1234); host_read(2'd0, v); chk("R2 address reg", v, 16'h1234);
    host_write(2'd1, 16'hBEEF); host_read(2'd1, v); chk("R2 data reg", v, 16'hBEEF);
    host_write(2'd3, 16'hFFFF); host_read(2'd3, v); chk("R2 unused select", v, 16'h0000);
    // R3: command without launch bit
    host_write(2'd2, 16'h000A);
    chk("R3 no launch no bus", {15'b0, mem_en}, 16'h0000);
    host_read(2'd2, v); chk("R3 command stored", v, 16'h000A);
    settle();
    host_read(2'd1, v); chk("R3 data untouched", v, 16'hBEEF);
  endtask

  task automatic t_word_read();
    logic [15:0] v;
    host_write(2'd0, 16'h0010);
    host_write(2'd2, 16'h0001);
    chk("R4 enable", {15'b0, mem_en}, 16'h0001);
    chk("R4 word address", {1'b0, mem_addr}, 16'h0008);
    chk("R4 read no we", {14'b0, mem_we}, 16'h0000);
    host_read(2'd2, v); chk("R10 busy during read", v, 16'h0011);
    @(negedge clk);
    chk("R4 single beat", {15'b0, mem_en}, 16'h0000);
    @(negedge clk);
    host_read(2'd1, v); chk("R4 word data", v, 16'h1122);
    host_read(2'd2, v); chk("R10 done clears", v, 16'h0000);
  endtask

  task automatic t_word_write_top();
    host_write(2'd0, 16'hFFE0);
    host_write(2'd1, 16'h7CD9);
    host_write(2'd2, 16'h0003);
    chk("R5 we both lanes", {14'b0, mem_we}, 16'h0003);
    chk("R5 write data", mem_wdata, 16'h7CD9);
    chk("R12 vector address", {1'b0, mem_addr}, 16'h7FF0);
    @(negedge clk);
    chk("R12 vector word landed", mem[8'hF0], 16'h7CD9);
  endtask

  task automatic t_byte_read();
    logic [15:0] v;
    host_write(2'd0, 16'h0020);
    host_write(2'd2, 16'h0009);
    repeat (2) @(negedge clk);
    host_read(2'd1, v); chk("R6 even byte", v, 16'h0076);
    host_write(2'd0, 16'h0021);
    host_write(2'd2, 16'h0009);
    repeat (2) @(negedge clk);
    host_read(2'd1, v); chk("R6 odd byte", v, 16'h00A9);
  endtask

  task automatic t_byte_write();
    host_write(2'd0, 16'h0020);
    host_write(2'd1, 16'h14B3);
    host_write(2'd2, 16'h000B);
    chk("R7 even lane we", {14'b0, mem_we}, 16'h0001);
    chk("R7 lane data", mem_wdata, 16'hB3B3);
    @(negedge clk);
    chk("R7 even merge", mem[8'h10], 16'hA9B3);
    host_write(2'd0, 16'h0021);
    host_write(2'd1, 16'h25C4);
    host_write(2'd2, 16'h000B);
    chk("R7 odd lane we", {14'b0, mem_we}, 16'h0002);
    @(negedge clk);
    chk("R7 odd merge", mem[8'h10], 16'hC4B3);
  endtask

  task automatic t_regfile();
    logic [15:0] v;
    host_write(2'd0, 16'h0005);
    host_write(2'd2, 16'h0005);
    chk("R8 no memory enable", {15'b0, mem_en}, 16'h0000);
    @(negedge clk);
    host_read(2'd1, v); chk("R8 register read", v, 16'hAAAA);
    host_write(2'd0, 16'h0006);
    host_write(2'd1, 16'hCB54);
    host_write(2'd2, 16'h0007);
    chk("R9 write strobe", {15'b0, rf_we}, 16'h0001);
    chk("R9 index", {12'b0, rf_idx}, 16'h0006);
    @(negedge clk);
    chk("R9 strobe one cycle", {15'b0, rf_we}, 16'h0000);
    chk("R9 register landed", rf[6], 16'hCB54);
  endtask

  task automatic t_busy_lock();
    logic [15:0] v;
    host_write(2'd0, 16'h0040);
    host_write(2'd1, 16'h5555);
    host_write(2'd2, 16'h0003);
    // write during the busy cycle
    host_sel = 2'd1; host_wdata = 16'h9999; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    settle();
    host_read(2'd1, v); chk("R11 data write ignored", v, 16'h5555);
    chk("R11 memory holds first write", mem[8'h20], 16'h5555);
    host_read(2'd2, v); chk("R10 launch cleared, write kept", v, 16'h0002);
    // launch while busy is dropped
    host_write(2'd0, 16'h0060);
    host_write(2'd2, 16'h0001);
    host_sel = 2'd2; host_wdata = 16'h0003; host_wr = 1'b1;
    @(negedge clk);
    host_wr = 1'b0;
    chk("R11 no second launch", {15'b0, mem_en}, 16'h0000);
    @(negedge clk);
    host_read(2'd2, v); chk("R11 command unchanged", v, 16'h0000);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 16'h0000;
    for (int i = 0; i < 16; i++)  rf[i]  = 16'h0000;
    mem[8'h08] = 16'h1122;
    mem[8'h10] = 16'hA976;
    rf[5]      = 16'hAAAA;
    host_sel = 2'd0; host_wr = 1'b0; host_wdata = 16'h0000;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_regs();
    t_word_read();
    t_word_write_top();
    t_byte_read();
    t_byte_write();
    t_regfile();
    t_busy_lock();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule